// File: doc/BRIEF.md
# Two-Port Mailbox Interrupt Flags

This block produces the port-to-port message interrupts of a two-port shared memory. Each port, called A and B here, presents a chip enable, a write strobe, an address and write data on a common clock. Two locations at the top of the address space are reserved as mailboxes, one per direction. When port A writes the highest location, the word is kept and the interrupt toward port B goes active. Port B drops that interrupt by reading the same location. The other direction mirrors this on the location just below the highest.

The mailbox locations follow the address width parameter, so the block stays at the top of any array depth. Storage for the rest of the array is not part of this block. The interrupt outputs are active low. Every update is registered and appears one clock after the access that causes it.

Top module: `mbx_irq_pair`

## Requirements
- R1: While `rst` is high, both interrupt outputs are high (inactive) one clock later, and both stored words are zero.
- R2: An access on port A with `a_en`=1, `a_we`=1 and `a_addr` all ones drives `b_irq_n` low one clock later and loads `a_wdata` into `b_msg`.
- R3: A port B access with `b_en`=1, `b_we`=0 and `b_addr` all ones releases `b_irq_n` to high one clock later.
- R4: A port B access with `b_en`=1, `b_we`=1 and `b_addr` equal to all ones minus one drives `a_irq_n` low one clock later and loads `b_wdata` into `a_msg`.
- R5: A port A access with `a_en`=1, `a_we`=0 and `a_addr` equal to all ones minus one releases `a_irq_n` to high one clock later.
- R6: An access with its port's enable at 0 changes no interrupt and no stored word, whatever its address and write strobe.
- R7: Only the receiving port clears a flag. A read of a mailbox by the port that sends on it, or a write to the mailbox of the opposite direction, changes neither interrupt.
- R8: Accesses to any address below the two mailbox locations change no interrupt and no stored word.
- R9: When a flag's set and its clear occur in the same cycle, the flag ends up set (output low) and the new word is stored.
- R10: An active interrupt stays low until it is cleared. A second write while it is active replaces the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_en | input | 1 | Port A chip enable, active high |
| a_we | input | 1 | Port A write strobe (1 write, 0 read) |
| a_addr | input | AW | Port A address |
| a_wdata | input | DW | Port A write data |
| b_en | input | 1 | Port B chip enable, active high |
| b_we | input | 1 | Port B write strobe (1 write, 0 read) |
| b_addr | input | AW | Port B address |
| b_wdata | input | DW | Port B write data |
| a_irq_n | output | 1 | Interrupt to port A, active low |
| b_irq_n | output | 1 | Interrupt to port B, active low |
| a_msg | output | DW | Last word port B left for port A |
| b_msg | output | DW | Last word port A left for port B |

## Verification
The bench builds the block with AW=5 and DW=8. With these values the two mailboxes sit at 31 and 30. This puts the address just below them (29) and address zero within a few directed accesses, so the bench can confirm that the decode does not alias onto nearby addresses. The narrow data width keeps every stored word easy to tell apart, and this shows plainly when an overwrite or a same-cycle set and clear updates the word.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic set_req;
        logic clr_req;
    } flag_ctl_t;

    function automatic acc_kind_e classify(input logic en, input logic we);
        if (!en)    return ACC_IDLE;
        else if (we) return ACC_WRITE;
        else         return ACC_READ;
    endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
    parameter int AW = 12
) (
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] send_addr,
    input  logic [AW-1:0] recv_addr,
    output logic          send_hit,
    output logic          recv_hit
);
    import mbx_pkg::*;

    acc_kind_e kind;

    always_comb begin
        kind     = classify(en, we);
        send_hit = (kind == ACC_WRITE) && (addr == send_addr);
        recv_hit = (kind == ACC_READ)  && (addr == recv_addr);
    end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag #(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  mbx_pkg::flag_ctl_t ctl,
    input  logic [DW-1:0]   wdata,
    output logic            irq_n,
    output logic [DW-1:0]   word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_n <= 1'b1;
            word  <= '0;
        end else if (ctl.set_req) begin
            irq_n <= 1'b0;
            word  <= wdata;
        end else if (ctl.clr_req) begin
            irq_n <= 1'b1;
        end
    end
endmodule

// File: rtl/mbx_irq_pair.sv
module mbx_irq_pair #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic          a_irq_n,
    output logic          b_irq_n,
    output logic [DW-1:0] a_msg,
    output logic [DW-1:0] b_msg
);
    import mbx_pkg::*;

    localparam int NPORT = 2;
    localparam logic [AW-1:0] BOX_TO_B = {AW{1'b1}};
    localparam logic [AW-1:0] BOX_TO_A = {AW{1'b1}} - 1'b1;

    logic          p_en    [NPORT];
    logic          p_we    [NPORT];
    logic [AW-1:0] p_addr  [NPORT];
    logic [DW-1:0] p_wdata [NPORT];
    logic [AW-1:0] p_send  [NPORT];
    logic [AW-1:0] p_recv  [NPORT];
    logic          send_hit[NPORT];
    logic          recv_hit[NPORT];
    logic          irq_n   [NPORT];
    logic [DW-1:0] word    [NPORT];

    always_comb begin
        p_en[0] = a_en;   p_we[0] = a_we;   p_addr[0] = a_addr;   p_wdata[0] = a_wdata;
        p_en[1] = b_en;   p_we[1] = b_we;   p_addr[1] = b_addr;   p_wdata[1] = b_wdata;
        p_send[0] = BOX_TO_B;  p_recv[0] = BOX_TO_A;
        p_send[1] = BOX_TO_A;  p_recv[1] = BOX_TO_B;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam int PEER = NPORT - 1 - p;
        flag_ctl_t ctl;

        mbx_decode #(.AW(AW)) u_dec (
            .en        (p_en[p]),
            .we        (p_we[p]),
            .addr      (p_addr[p]),
            .send_addr (p_send[p]),
            .recv_addr (p_recv[p]),
            .send_hit  (send_hit[p]),
            .recv_hit  (recv_hit[p])
        );

        // Flag p is the interrupt toward port p: set by the peer, cleared by p.
        always_comb begin
            ctl.set_req = send_hit[PEER];
            ctl.clr_req = recv_hit[p];
        end

        mbx_flag #(.DW(DW)) u_flag (
            .clk   (clk),
            .rst   (rst),
            .ctl   (ctl),
            .wdata (p_wdata[PEER]),
            .irq_n (irq_n[p]),
            .word  (word[p])
        );
    end

    assign a_irq_n = irq_n[0];
    assign b_irq_n = irq_n[1];
    assign a_msg   = word[0];
    assign b_msg   = word[1];
endmodule

module mbx_irq_pair_chk #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          a_en,
    input logic          a_we,
    input logic [AW-1:0] a_addr,
    input logic [DW-1:0] a_wdata,
    input logic          b_en,
    input logic          b_we,
    input logic [AW-1:0] b_addr,
    input logic [DW-1:0] b_wdata,
    input logic          a_irq_n,
    input logic          b_irq_n,
    input logic [DW-1:0] a_msg,
    input logic [DW-1:0] b_msg
);
    localparam logic [AW-1:0] HI = {AW{1'b1}};
    localparam logic [AW-1:0] LO = {AW{1'b1}} - 1'b1;

    logic armed;
    always_ff @(posedge clk) armed <= !rst;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (a_irq_n && b_irq_n && a_msg == '0 && b_msg == '0));

    // R2
    set_b_chk: assert property (@(posedge clk) disable iff (rst)
        (a_en && a_we && a_addr == HI) |=> (!b_irq_n && b_msg == $past(a_wdata)));

    // R4
    set_a_chk: assert property (@(posedge clk) disable iff (rst)
        (b_en && b_we && b_addr == LO) |=> (!a_irq_n && a_msg == $past(b_wdata)));

    // R3
    clr_b_chk: assert property (@(posedge clk) disable iff (rst)
        (b_en && !b_we && b_addr == HI && !(a_en && a_we && a_addr == HI)) |=> b_irq_n);

    // R5
    clr_a_chk: assert property (@(posedge clk) disable iff (rst)
        (a_en && !a_we && a_addr == LO && !(b_en && b_we && b_addr == LO)) |=> a_irq_n);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !a_en && !b_en) |=> ($stable(a_irq_n) && $stable(b_irq_n)
                                       && $stable(a_msg) && $stable(b_msg)));

    // R7
    sender_read_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && a_en && !a_we && a_addr == HI && !b_en) |=> $stable(b_irq_n));
endmodule

bind mbx_irq_pair mbx_irq_pair_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/mbx_irq_pair_test.sv
module mbx_irq_pair_test;
    localparam int AW = 5;
    localparam int DW = 8;
    localparam logic [AW-1:0] HI = 5'd31;
    localparam logic [AW-1:0] LO = 5'd30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_en = 0, a_we = 0, b_en = 0, b_we = 0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic a_irq_n, b_irq_n;
    logic [DW-1:0] a_msg, b_msg;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    mbx_irq_pair #(.AW(AW), .DW(DW)) uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic status(input string req, input int ai, input int bi, input int am, input int bm);
        chk({req, " a_irq_n"}, int'(a_irq_n), ai);
        chk({req, " b_irq_n"}, int'(b_irq_n), bi);
        chk({req, " a_msg"},   int'(a_msg),   am);
        chk({req, " b_msg"},   int'(b_msg),   bm);
    endtask

    // One clock of stimulus on both ports; returns at the next falling edge.
    task automatic cyc(input logic ae, input logic aw, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                       input logic be, input logic bw, input logic [AW-1:0] ba, input logic [DW-1:0] bd);
        a_en = ae; a_we = aw; a_addr = aa; a_wdata = ad;
        b_en = be; b_we = bw; b_addr = ba; b_wdata = bd;
        @(negedge clk);
        a_en = 0; a_we = 0; b_en = 0; b_we = 0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        status("R1", 1, 1, 0, 0);
    endtask

    task automatic t_a_to_b();
        cyc(1, 1, HI, 8'h5A, 0, 0, '0, '0);
        status("R2", 1, 0, 0, 8'h5A);
        cyc(0, 0, '0, '0, 0, 0, '0, '0);
        chk("R10 hold", int'(b_irq_n), 0);
        cyc(0, 0, '0, '0, 1, 0, HI, '0);
        status("R3", 1, 1, 0, 8'h5A);
    endtask

    task automatic t_b_to_a();
        cyc(0, 0, '0, '0, 1, 1, LO, 8'hC3);
        status("R4", 0, 1, 8'hC3, 8'h5A);
        cyc(1, 0, LO, '0, 0, 0, '0, '0);
        status("R5", 1, 1, 8'hC3, 8'h5A);
    endtask

    task automatic t_disabled();
        cyc(0, 1, HI, 8'h11, 0, 1, LO, 8'h22);
        status("R6 set", 1, 1, 8'hC3, 8'h5A);
        cyc(1, 1, HI, 8'h33, 0, 0, '0, '0);
        cyc(0, 0, '0, '0, 0, 0, HI, '0);
        chk("R6 clr b_irq_n", int'(b_irq_n), 0);
        cyc(0, 0, '0, '0, 1, 0, HI, '0);
        chk("R6 cleanup", int'(b_irq_n), 1);
    endtask

    task automatic t_wrong_port();
        cyc(1, 1, HI, 8'h44, 1, 1, LO, 8'h55);
        status("R7 setup", 0, 0, 8'h55, 8'h44);
        cyc(1, 0, HI, '0, 1, 0, LO, '0);
        status("R7 sender reads", 0, 0, 8'h55, 8'h44);
        cyc(0, 0, '0, '0, 1, 0, HI, '0);
        cyc(1, 0, LO, '0, 0, 0, '0, '0);
        status("R7 receivers clear", 1, 1, 8'h55, 8'h44);
        cyc(1, 1, LO, 8'h66, 1, 1, HI, 8'h77);
        status("R7 wrong-box writes", 1, 1, 8'h55, 8'h44);
    endtask

    task automatic t_other_addr();
        cyc(1, 1, 5'd29, 8'h88, 1, 1, 5'd29, 8'h99);
        status("R8 addr29", 1, 1, 8'h55, 8'h44);
        cyc(1, 1, 5'd0, 8'hAA, 1, 1, 5'd0, 8'hBB);
        status("R8 addr0", 1, 1, 8'h55, 8'h44);
    endtask

    task automatic t_collision();
        cyc(1, 1, HI, 8'h01, 1, 0, HI, '0);
        status("R9 b flag", 1, 0, 8'h55, 8'h01);
        cyc(1, 0, LO, '0, 1, 1, LO, 8'h02);
        status("R9 a flag", 0, 0, 8'h02, 8'h01);
    endtask

    task automatic t_overwrite();
        cyc(1, 1, HI, 8'hE7, 0, 0, '0, '0);
        status("R10 overwrite", 0, 0, 8'h02, 8'hE7);
        cyc(1, 0, LO, '0, 1, 0, HI, '0);
        status("R10 cleared", 1, 1, 8'h02, 8'hE7);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_a_to_b();
        t_b_to_a();
        t_disabled();
        t_wrong_port();
        t_other_addr();
        t_collision();
        t_overwrite();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule